// File: doc/BRIEF.md
# Word-Parallel CRC-16 Generator

This block accumulates a 16-bit cyclic redundancy check over a stream of 16-bit words taken from a parallel data bus. It has no bit-rate clock. The register advances once for every word, on the edge of a word clock that comes from the bus strobe. For each word that is accepted, combinational logic computes the next check value from the current one and the incoming word. The result is the same as sixteen serial shifts through the generator x^16 + x^12 + x^5 + 1, entering word bit 0 first and word bit 15 last.

The logic builds a chain of sixteen feedback terms, each formed from one data bit, one bit of the current check value and earlier terms of the chain. A fold stage then combines these terms into the next value. The host pulses a load input at the start of every burst to return the register to a fixed seed. After that, each valid word is folded in, and the value holds in every cycle that carries no word.

Top module: `crc16w_top`

## Requirements
- R1: While reset is high at a clock edge, the register takes the seed value (default 16'h4ABA), and crc_o shows that value after the edge.
- R2: A high load_i at a clock edge sets the register to the seed. This takes priority over a word offered in the same cycle, which is discarded.
- R3: When word_vld_i is high and load_i is low at an edge, crc_o after that edge equals the result of sixteen serial steps on the previous value. Step i (i from 0 to 15) computes fb = word_i[i] XOR crc[15], shifts crc left by one with a zero into bit 0, and XORs in 16'h1021 when fb is 1.
- R4: When word_vld_i and load_i are both low at an edge, crc_o keeps its value, whatever word_i carries.
- R5: Over a burst of back-to-back valid words that starts with a load, the final crc_o equals the serial computation over all the words' bits in arrival order, word by word and bit 0 first.
- R6: After a load, the check value of a new burst depends only on the words of that burst and not on any earlier history.
- R7: The mapping is sensitive to bit order. From the seed, a word with only bit 0 set and a word with only bit 15 set each give the value that R3 defines for it, and the two values differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock derived from the bus strobe |
| rst | input | 1 | Synchronous active-high reset to the seed |
| load_i | input | 1 | Synchronous seed load at the start of a burst |
| word_vld_i | input | 1 | Marks the cycle in which word_i is folded in |
| word_i | input | 16 | Data word from the bus |
| crc_o | output | 16 | Current check value |

## Verification
The bench drives several kinds of word. An all-zero word exercises the contribution of the register alone. An all-ones word exercises every data path at once. Single-bit words at bit 0 and at bit 15 show whether the bits enter in the right order.

Random bursts of lengths 1, 2, 5, 16 and 33 are compared against a bit-serial model. Some of these bursts run back to back and some have idle gaps with random data on the bus. The gaps separate correct holding from spurious updates. A load that arrives together with a valid word shows that load wins. Repeating a burst after unrelated traffic shows that no earlier history leaks into the result.

// File: rtl/crc16w_pkg.sv
package crc16w_pkg;

    localparam int CRC_W = 16;

    typedef logic [CRC_W-1:0] crc_t;

    localparam crc_t CRC_POLY_DEF = 16'h1021;
    localparam crc_t CRC_SEED_DEF = 16'h4ABA;

    // One bus-side command per word clock
    typedef struct packed {
        logic load;
        logic vld;
        crc_t word;
    } crc_cmd_t;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_FOLD = 2'd1,
        OP_SEED = 2'd2
    } crc_op_e;

    // Decode the command into the register operation; seeding wins
    function automatic crc_op_e decode_op(input crc_cmd_t cmd);
        if (cmd.load)
            return OP_SEED;
        else if (cmd.vld)
            return OP_FOLD;
        else
            return OP_HOLD;
    endfunction

    // Source index of an earlier feedback term fed by tap t into term k
    // (1-based terms); returns 0 when there is no such term.
    function automatic int earlier_term(input int k, input int t);
        int src;
        src = k - (CRC_W - t);
        if (t > 0 && src >= 1)
            return src;
        else
            return 0;
    endfunction

    // Feedback term index reaching output bit j through tap t; 0 if none
    function automatic int fold_term(input int j, input int t);
        int k;
        k = CRC_W + t - j;
        if (k >= 1 && k <= CRC_W)
            return k;
        else
            return 0;
    endfunction

endpackage

// File: rtl/crc16w_fb.sv
module crc16w_fb
    import crc16w_pkg::*;
#(
    parameter crc_t POLY = CRC_POLY_DEF
) (
    input  crc_t cur_i,
    input  crc_t word_i,
    output crc_t fb_o
);
    // Term k (1-based) is fb_o[k-1]: data bit k-1, register bit W-k, and
    // every earlier term that a polynomial tap carries to the top.
    always_comb begin
        fb_o = '0;
        for (int k = 1; k <= CRC_W; k++) begin
            logic acc;
            acc = word_i[k-1] ^ cur_i[CRC_W-k];
            for (int t = 1; t < CRC_W; t++) begin
                if (POLY[t] && earlier_term(k, t) != 0)
                    acc = acc ^ fb_o[earlier_term(k, t) - 1];
            end
            fb_o[k-1] = acc;
        end
    end
endmodule

// File: rtl/crc16w_fold.sv
module crc16w_fold
    import crc16w_pkg::*;
#(
    parameter crc_t POLY = CRC_POLY_DEF
) (
    input  crc_t fb_i,
    output crc_t nxt_o
);
    // Output bit j collects each term inserted at tap t whose remaining
    // shifts carry it to position j.
    for (genvar j = 0; j < CRC_W; j++) begin : g_bit
        always_comb begin
            nxt_o[j] = 1'b0;
            for (int t = 0; t < CRC_W; t++) begin
                if (POLY[t] && fold_term(j, t) != 0)
                    nxt_o[j] = nxt_o[j] ^ fb_i[fold_term(j, t) - 1];
            end
        end
    end
endmodule

// File: rtl/crc16w_reg.sv
module crc16w_reg
    import crc16w_pkg::*;
#(
    parameter crc_t SEED = CRC_SEED_DEF
) (
    input  logic    clk,
    input  logic    rst,
    input  crc_op_e op_i,
    input  crc_t    nxt_i,
    output crc_t    q_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= SEED;
        end else begin
            unique case (op_i)
                OP_SEED: q_o <= SEED;
                OP_FOLD: q_o <= nxt_i;
                default: q_o <= q_o;
            endcase
        end
    end
endmodule

// File: rtl/crc16w_top.sv
module crc16w_top
    import crc16w_pkg::*;
#(
    parameter crc_t SEED = CRC_SEED_DEF,
    parameter crc_t POLY = CRC_POLY_DEF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        load_i,
    input  logic        word_vld_i,
    input  logic [15:0] word_i,
    output logic [15:0] crc_o
);
    crc_cmd_t cmd;
    crc_op_e  op;
    crc_t     cur;
    crc_t     fb;
    crc_t     nxt;

    assign cmd = '{load: load_i, vld: word_vld_i, word: word_i};
    assign op  = decode_op(cmd);

    crc16w_fb #(.POLY(POLY)) fb_i (
        .cur_i  (cur),
        .word_i (cmd.word),
        .fb_o   (fb)
    );

    crc16w_fold #(.POLY(POLY)) fold_i (
        .fb_i  (fb),
        .nxt_o (nxt)
    );

    crc16w_reg #(.SEED(SEED)) reg_i (
        .clk   (clk),
        .rst   (rst),
        .op_i  (op),
        .nxt_i (nxt),
        .q_o   (cur)
    );

    assign crc_o = cur;
endmodule

// File: rtl/crc16w_chk.sv
module crc16w_chk
    import crc16w_pkg::*;
#(
    parameter crc_t SEED = CRC_SEED_DEF,
    parameter crc_t POLY = CRC_POLY_DEF
) (
    input logic        clk,
    input logic        rst,
    input logic        load_i,
    input logic        word_vld_i,
    input logic [15:0] word_i,
    input logic [15:0] crc_o
);
    function automatic crc_t serial_step(input crc_t c, input crc_t d);
        crc_t s;
        logic b;
        s = c;
        for (int i = 0; i < CRC_W; i++) begin
            b = d[i] ^ s[CRC_W-1];
            s = {s[CRC_W-2:0], 1'b0} ^ (b ? POLY : '0);
        end
        return s;
    endfunction

    // R1: reset returns the seed
    a_r1_reset_seed: assert property (@(posedge clk)
        rst |=> crc_o == SEED);

    // R2: load returns the seed, even with a word present
    a_r2_load_seed: assert property (@(posedge clk) disable iff (rst)
        load_i |=> crc_o == SEED);

    // R3: an accepted word matches sixteen serial steps
    a_r3_serial_match: assert property (@(posedge clk) disable iff (rst)
        (word_vld_i && !load_i) |=>
            crc_o == serial_step($past(crc_o), $past(word_i)));

    // R4: no word, no change
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!word_vld_i && !load_i) |=> $stable(crc_o));

    // R3: output never unknown after reset
    a_r3_known: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(crc_o));
endmodule

bind crc16w_top crc16w_chk #(.SEED(SEED), .POLY(POLY)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_i),
    .word_vld_i (word_vld_i),
    .word_i     (word_i),
    .crc_o      (crc_o)
);

// File: tb/crc16w_top_tb_top.sv
module crc16w_top_tb_top;
    localparam logic [15:0] SEED = 16'h4ABA;
    localparam logic [15:0] POLY = 16'h1021;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_i = 1'b0;
    logic        word_vld_i = 1'b0;
    logic [15:0] word_i = '0;
    logic [15:0] crc_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_crc;
    logic [15:0] saved;
    logic [15:0] v_lo;
    logic [15:0] v_hi;

    always #10 clk = ~clk;

    crc16w_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load_i),
        .word_vld_i (word_vld_i),
        .word_i     (word_i),
        .crc_o      (crc_o)
    );

    function automatic logic [15:0] ref_step(input logic [15:0] c,
                                             input logic [15:0] d);
        logic [15:0] s;
        logic b;
        s = c;
        for (int i = 0; i < 16; i++) begin
            b = d[i] ^ s[15];
            s = {s[14:0], 1'b0} ^ (b ? POLY : 16'h0000);
        end
        return s;
    endfunction

    task automatic check(input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive after the falling edge, let one rising edge pass, sample at the next falling edge
    task automatic cycle(input logic ld, input logic vl, input logic [15:0] w);
        load_i     = ld;
        word_vld_i = vl;
        word_i     = w;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic feed(input logic [15:0] w);
        cycle(1'b0, 1'b1, w);
        exp_crc = ref_step(exp_crc, w);
    endtask

    task automatic run_burst(input int len, input bit gaps);
        cycle(1'b1, 1'b0, 16'($urandom));
        exp_crc = SEED;
        for (int n = 0; n < len; n++) begin
            feed(16'($urandom));
            if (gaps && ($urandom % 3 == 0)) begin
                cycle(1'b0, 1'b0, 16'($urandom));
                check("R4 idle gap", crc_o, exp_crc);
            end
        end
        check("R5 burst result", crc_o, exp_crc);
    endtask

    initial begin
        int cnt;
        cnt = 0;
        while (cnt < 100000) begin
            @(posedge clk);
            cnt++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        cycle(1'b0, 1'b1, 16'hFFFF);
        cycle(1'b0, 1'b0, 16'h0000);
        check("R1 reset seed", crc_o, SEED);
        rst = 1'b0;
        exp_crc = SEED;

        // directed words
        feed(16'h0000);
        check("R3 zero word", crc_o, exp_crc);
        feed(16'hFFFF);
        check("R3 ones word", crc_o, exp_crc);

        cycle(1'b1, 1'b0, 16'h0);
        feed(16'h0001);
        v_lo = crc_o;
        check("R7 bit0 word", v_lo, ref_step(SEED, 16'h0001));
        cycle(1'b1, 1'b0, 16'h0);
        exp_crc = SEED;
        feed(16'h8000);
        v_hi = crc_o;
        check("R7 bit15 word", v_hi, ref_step(SEED, 16'h8000));
        checks++;
        if (v_lo === v_hi) begin
            errors++;
            $display("FAIL R7 order: actual=%h expected!=%h", v_hi, v_lo);
        end

        // hold with random data on the bus
        for (int i = 0; i < 4; i++) begin
            cycle(1'b0, 1'b0, 16'($urandom));
            check("R4 hold", crc_o, exp_crc);
        end

        // load beats a simultaneous word
        feed(16'h1234);
        cycle(1'b1, 1'b1, 16'hBEEF);
        exp_crc = SEED;
        check("R2 load priority", crc_o, SEED);

        // random bursts
        run_burst(1, 1'b0);
        run_burst(2, 1'b1);
        run_burst(5, 1'b0);
        run_burst(16, 1'b1);
        run_burst(33, 1'b0);

        // per-word check on random words
        cycle(1'b1, 1'b0, 16'h0);
        exp_crc = SEED;
        for (int i = 0; i < 20; i++) begin
            feed(16'($urandom));
            check("R3 random word", crc_o, exp_crc);
        end

        // history independence: same burst twice with traffic between
        cycle(1'b1, 1'b0, 16'h0);
        exp_crc = SEED;
        feed(16'hA5A5);
        feed(16'h0F0F);
        feed(16'h1357);
        saved = crc_o;
        for (int i = 0; i < 7; i++) feed(16'($urandom));
        cycle(1'b1, 1'b0, 16'h0);
        exp_crc = SEED;
        feed(16'hA5A5);
        feed(16'h0F0F);
        feed(16'h1357);
        check("R6 restart", crc_o, saved);
        check("R5 short burst", crc_o, exp_crc);

        // reset mid-stream
        feed(16'h7777);
        rst = 1'b1;
        cycle(1'b0, 1'b1, 16'h4444);
        check("R1 reset midstream", crc_o, SEED);
        rst = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule